// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block moves a small processor subsystem between normal operation and three reduced-power states. Software programs a two-bit mode field and an external-clock option in an 8-bit control register, and sets a separate permission bit before it may request the deepest state. When the core reports that it has executed its halt instruction, the sequencer enters the programmed state on the next clock. It then drives four clock-gate enables: core clock, peripheral clock group, system clock and external clock output.

The block runs on an always-on clock. It leaves a low-power state when a reset arrives, or when an interrupt request that is both pending and enabled has passed through a synchronizer. On that wakeup every gate reopens, and an acknowledge pulse marks that the exit was caused by an interrupt. A status output reports the state the block is in.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset both registers read zero, the status reports run (00), `halted` is low and all four clock enables are high.
- R2: Register select 0 holds the mode field in bits 7:6 and the external-clock option in bit 3. Bits 5:4 and 2:0 read as zero, and writes to them have no effect.
- R3: Register select 1 holds the stop permission in bit 0. Bits 7:1 read as zero.
- R4: A `stop_req` pulse while running raises `halted` after the next rising edge, and the status then shows the programmed field (00 run, 01 doze, 10 wait, 11 stop).
- R5: A `stop_req` with field 11 while the stop permission is clear is ignored. `halted` stays low and all clocks keep running.
- R6: With field 00, a `stop_req` halts the block while all four clock enables stay high.
- R7: Wait gates only the core clock. Doze gates the core and peripheral clocks. Stop gates the core, peripheral and system clocks.
- R8: The external clock enable is low only in stop with bit 3 set. It is high in stop with bit 3 clear and in every other state.
- R9: An interrupt that is high on both `irq_req[i]` and `irq_enable[i]` at rising edge k clears `halted` after edge k+2, and `irq_ack` is high for exactly that one cycle. A request whose enable bit is low does not wake the block.
- R10: The mode field stays readable and writable while halted. A write does not change the current state, and it takes effect at the next entry.
- R11: A `stop_req` while already halted is ignored.
- R12: Asserting reset while halted returns the block to run with all clocks enabled and no `irq_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = mode control register, 1 = stop permission register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| stop_req | input | 1 | One-cycle pulse when the core executes its halt instruction |
| irq_req | input | NIRQ | Asynchronous interrupt requests |
| irq_enable | input | NIRQ | Per-request enable mask |
| halted | output | 1 | Core is halted in a low-power state |
| mode_status | output | 2 | Current state code |
| cpu_clk_en | output | 1 | Core clock gate enable |
| per_clk_en | output | 1 | Peripheral clock group gate enable |
| sys_clk_en | output | 1 | System clock gate enable (low forces clock low) |
| ext_clk_en | output | 1 | External clock output enable |
| irq_ack | output | 1 | One-cycle pulse on wakeup by interrupt |

## Verification
The bench builds the block with four interrupt lines and a two-stage synchronizer, the default values. Four lines are enough to show that an individual mask bit can hold back its own request while another request still wakes the block. With two stages the wakeup timing is short and fixed, so the model can predict the exact release edge for every entry into each of the four states. The model also covers a reset during stop, a repeated halt strobe, and the ignored stop request.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int REG_W = 8;

  typedef enum logic [1:0] {
    M_RUN  = 2'b00,
    M_DOZE = 2'b01,
    M_WAIT = 2'b10,
    M_STOP = 2'b11
  } pmode_e;

  typedef struct packed {
    logic cpu;
    logic per;
    logic sys;
    logic ext;
  } gates_t;

  function automatic gates_t gate_map(logic lp, pmode_e m, logic ext_off);
    gates_t g;
    g.cpu = !(lp && m != M_RUN);
    g.per = !(lp && (m == M_DOZE || m == M_STOP));
    g.sys = !(lp && m == M_STOP);
    g.ext = !(lp && m == M_STOP && ext_off);
    return g;
  endfunction

  function automatic logic entry_allowed(pmode_e m, logic stop_ok);
    return (m != M_STOP) || stop_ok;
  endfunction
endpackage

// File: rtl/lpm_regs.sv
module lpm_regs
  import lpm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             sel,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output pmode_e           mode_field,
  output logic             ext_off,
  output logic             stop_ok
);
  localparam int MODE_HI = 7;
  localparam int MODE_LO = 6;
  localparam int EXT_BIT = 3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_field <= M_RUN;
      ext_off    <= 1'b0;
      stop_ok    <= 1'b0;
    end else if (wr) begin
      if (!sel) begin
        mode_field <= pmode_e'(wdata[MODE_HI:MODE_LO]);
        ext_off    <= wdata[EXT_BIT];
      end else begin
        stop_ok    <= wdata[0];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (!sel) begin
      rdata[MODE_HI:MODE_LO] = mode_field;
      rdata[EXT_BIT]         = ext_off;
    end else begin
      rdata[0] = stop_ok;
    end
  end
endmodule

// File: rtl/lpm_sync.sv
module lpm_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import lpm_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   stop_req,
  input  pmode_e mode_field,
  input  logic   stop_ok,
  input  logic   wake_req,
  output logic   in_lp,
  output pmode_e cur_mode,
  output logic   irq_ack,
  output logic   entry_evt,
  output logic   wake_evt
);
  assign entry_evt = !in_lp && stop_req && entry_allowed(mode_field, stop_ok);
  assign wake_evt  = in_lp && wake_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_lp    <= 1'b0;
      cur_mode <= M_RUN;
      irq_ack  <= 1'b0;
    end else begin
      irq_ack <= wake_evt;
      if (entry_evt) begin
        in_lp    <= 1'b1;
        cur_mode <= mode_field;
      end else if (wake_evt) begin
        in_lp    <= 1'b0;
        cur_mode <= M_RUN;
      end
    end
  end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int NIRQ        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             stop_req,
  input  logic [NIRQ-1:0]  irq_req,
  input  logic [NIRQ-1:0]  irq_enable,
  output logic             halted,
  output logic [1:0]       mode_status,
  output logic             cpu_clk_en,
  output logic             per_clk_en,
  output logic             sys_clk_en,
  output logic             ext_clk_en,
  output logic             irq_ack
);
  pmode_e          mode_field, cur_mode;
  logic            ext_off, stop_ok, in_lp;
  logic [NIRQ-1:0] irq_sync;
  logic            wake_req, entry_evt, wake_evt;
  gates_t          g;

  lpm_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
    .rdata(reg_rdata), .mode_field(mode_field), .ext_off(ext_off), .stop_ok(stop_ok)
  );

  lpm_sync #(.W(NIRQ), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(irq_req), .q(irq_sync)
  );

  assign wake_req = |(irq_sync & irq_enable);

  lpm_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .mode_field(mode_field),
    .stop_ok(stop_ok), .wake_req(wake_req), .in_lp(in_lp), .cur_mode(cur_mode),
    .irq_ack(irq_ack), .entry_evt(entry_evt), .wake_evt(wake_evt)
  );

  assign g           = gate_map(in_lp, cur_mode, ext_off);
  assign cpu_clk_en  = g.cpu;
  assign per_clk_en  = g.per;
  assign sys_clk_en  = g.sys;
  assign ext_clk_en  = g.ext;
  assign halted      = in_lp;
  assign mode_status = cur_mode;
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       halted,
  input logic [1:0] mode_status,
  input logic       cpu_clk_en,
  input logic       per_clk_en,
  input logic       sys_clk_en,
  input logic       ext_clk_en,
  input logic       irq_ack,
  input logic       stop_ok,
  input logic       stop_req,
  input logic       wake_evt
);
  p_stop_needs_perm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_clk_en) |-> $past(stop_ok));

  p_run_code_keeps_clocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && mode_status == 2'b00) |-> (cpu_clk_en && per_clk_en && sys_clk_en && ext_clk_en));

  p_wait_core_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && mode_status == 2'b10) |-> (!cpu_clk_en && per_clk_en && sys_clk_en));

  p_ext_only_in_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_clk_en |-> (!sys_clk_en && halted));

  p_ack_on_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |=> (irq_ack && !halted));

  p_strobe_while_halted_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && stop_req && !wake_evt) |=> (halted && $stable(mode_status)));

  p_reset_run_r1: assert property (@(posedge clk)
    !rst_n |-> (!halted && cpu_clk_en && sys_clk_en && !irq_ack));
endmodule

bind lpm_ctrl lpm_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .halted(halted), .mode_status(mode_status),
  .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .sys_clk_en(sys_clk_en),
  .ext_clk_en(ext_clk_en), .irq_ack(irq_ack), .stop_ok(stop_ok),
  .stop_req(stop_req), .wake_evt(wake_evt)
);

// File: tb/lpm_ctrl_tb.sv
module lpm_ctrl_tb;
  localparam int NIRQ = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 0, reg_sel = 0, stop_req = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic [NIRQ-1:0] irq_req = 0, irq_enable = 0;
  logic halted, cpu_clk_en, per_clk_en, sys_clk_en, ext_clk_en, irq_ack;
  logic [1:0] mode_status;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lpm_ctrl u_dut (.*);

  // reference model: plain variables, updated per rising edge
  int m_field, m_ext, m_perm, m_lp, m_mode, m_ack;
  int s1, s2;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_field = 0; m_ext = 0; m_perm = 0; m_lp = 0; m_mode = 0; m_ack = 0; s1 = 0; s2 = 0;
    end else begin
      int wake;
      wake = (m_lp != 0) && ((s2 & irq_enable) != 0);
      m_ack = wake;
      if (m_lp == 0 && stop_req && !(m_field == 3 && m_perm == 0)) begin
        m_lp = 1; m_mode = m_field;
      end else if (wake) begin
        m_lp = 0; m_mode = 0;
      end
      if (reg_wr) begin
        if (!reg_sel) begin m_field = reg_wdata[7:6]; m_ext = reg_wdata[3]; end
        else m_perm = reg_wdata[0];
      end
      s2 = s1; s1 = irq_req;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    int e_rd;
    cycles++;
    if (!done) begin
      e_rd = reg_sel ? m_perm : ((m_field << 6) | (m_ext << 3));
      chk(reg_sel ? "R3 rdata" : "R2 rdata", reg_rdata, e_rd);
      chk("R4 halted", halted, m_lp);
      chk("R4 status", mode_status, m_mode);
      chk("R7 cpu", cpu_clk_en, !(m_lp && m_mode != 0));
      chk("R7 per", per_clk_en, !(m_lp && (m_mode == 1 || m_mode == 3)));
      chk("R7 sys", sys_clk_en, !(m_lp && m_mode == 3));
      chk("R8 ext", ext_clk_en, !(m_lp && m_mode == 3 && m_ext));
      chk("R9 ack", irq_ack, m_ack);
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(bit sel, logic [7:0] d);
    reg_wr = 1; reg_sel = sel; reg_wdata = d; step();
    reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic strobe();
    stop_req = 1; step(); stop_req = 0;
  endtask

  task automatic wake(logic [NIRQ-1:0] r);
    irq_req = r; step(4); irq_req = 0; step(2);
  endtask

  initial begin
    step(2);
    #1 rst_n = 1;
    // R1: reset state
    chk("R1 halted", halted, 0);
    chk("R1 cpu", cpu_clk_en, 1);
    chk("R1 rdata", reg_rdata, 0);
    // R2: reserved bits
    wr(0, 8'hFF); reg_sel = 0; step();
    chk("R2 layout", reg_rdata, 8'hC8);
    // R3
    wr(1, 8'hFE); reg_sel = 1; step(); chk("R3 perm clr", reg_rdata, 0);
    // R5: stop without permission
    wr(0, 8'hC0); strobe(); step(2);
    chk("R5 no entry", halted, 0);
    chk("R5 sys on", sys_clk_en, 1);
    // R6: run-coded
    wr(0, 8'h00); strobe();
    chk("R6 halted", halted, 1);
    chk("R6 cpu on", cpu_clk_en, 1);
    irq_enable = 4'b0010; wake(4'b0010);
    // R7: wait, doze
    wr(0, 8'h80); strobe(); step();
    chk("R7 wait per", per_clk_en, 1);
    // R9: masked request does not wake
    irq_enable = 4'b0001; irq_req = 4'b0100; step(5);
    chk("R9 masked", halted, 1);
    irq_req = 0; wake(4'b0001);
    chk("R9 woke", halted, 0);
    wr(0, 8'h40); strobe(); step();
    // R10: write while halted
    wr(0, 8'h88); reg_sel = 0; step();
    chk("R10 status kept", mode_status, 1);
    chk("R10 read", reg_rdata, 8'h88);
    // R11: strobe while halted
    strobe(); chk("R11 status", mode_status, 1);
    wake(4'b0001);
    // R8: stop with ext off, then ext on
    wr(1, 8'h01); wr(0, 8'hC8); strobe();
    chk("R8 ext off", ext_clk_en, 0);
    wake(4'b0001);
    wr(0, 8'hC0); strobe();
    chk("R8 ext on", ext_clk_en, 1);
    // R12: reset while in stop
    step(); #1 rst_n = 0; step(); #1 rst_n = 1;
    chk("R12 halted", halted, 0);
    chk("R12 sys", sys_clk_en, 1);
    chk("R12 ack", irq_ack, 0);
    step(3);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule